// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a parameterised set of external interrupt lines and turns each one into a pending bit. Each line is set up on its own. A trigger bit chooses level or edge sensing. A polarity bit gives the active level in level mode and the active edge in single-edge mode. A dual bit makes an edge-mode line fire on either edge. Software can also inject or remove edge-pending state for any line through a single edge-command word.

A pending line reaches the outputs only when its mask bit is set. Mask bits are changed only through two write-one-to-act words, one that sets and one that clears, and the resulting mask can be read back. Each line has a route word that sends it to one numbered output pin, to the non-maskable output, or to both. Every output is the OR of all lines that are pending, unmasked and routed to it. All access goes through a simple 32-bit register bus: writes are strobed and reads are combinational from the address.

Top module: `sisc_top`

## Requirements
- R1: After reset every pending bit and every mask bit is 0, all polarity bits are 1 (word at 0x040 reads 1 for each implemented line), trigger and dual bits are 0, and `pin_out` and `nmi_out` are low.
- R2: With the line's trigger bit at 0 (level mode, trigger words at 0x060), the pending bit read at 0x100 follows the input in the same cycle: polarity 1 means active-high and polarity 0 means active-low (polarity words at 0x040). Nothing is latched.
- R3: With trigger 1 and dual 0, polarity 1 latches pending on a rising input edge and polarity 0 latches it on a falling edge. The opposite edge sets nothing. The pending bit is visible one clock after the sampled edge.
- R4: With trigger 1 and dual 1 (dual words at 0x080), both rising and falling edges latch pending, whatever the polarity.
- R5: A latched edge-pending bit stays set until software writes the edge-command word at 0x004 with bit 31 = 0 and the line number in bits 7:0. That write clears it one clock later.
- R6: Writing the edge-command word with bit 31 = 1 and the line number in bits 7:0 sets that line's edge-pending bit. In edge mode this shows as pending.
- R7: Writing a 1 in bit n of the set-mask word (0x0A0) sets mask bit n, and writing a 1 in bit n of the clear-mask word (0x0C0) clears it. Zero bits have no effect. The current mask reads back at 0x0E0, 32 lines per word.
- R8: A line's route word sits at 0x400 + 4·n. When bit 31 is 1, the line drives `pin_out[bits 5:0]` while it is pending and unmasked. A pin number at or above NUM_PINS drives nothing. The route word reads back with only bits 31, 30 and 5:0 kept.
- R9: When bit 30 of a line's route word is 1, that line drives `nmi_out` while it is pending and unmasked.
- R10: The configuration word at 0x000 reports NUM_LINES in bits 23:16 and 0 elsewhere. An edge command whose line number is NUM_LINES or more changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | External interrupt lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 11 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pin_out | output | NUM_PINS | Interrupt output pins |
| nmi_out | output | 1 | Non-maskable interrupt output |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk` and is held low while reset is asserted. This keeps the first compare against the previous-cycle value from counting as a false edge. They also assume that no write lands on the same line's edge command in the same cycle as a hardware edge. The bench changes inputs and bus signals only on falling clock edges and keeps every line low through reset. It issues each edge-command clear while the input is steady, so every assertion sees a clean, single cause for each change of pending state.

// File: rtl/sisc_pkg.sv
// Shared constants and types for the shared interrupt source controller.
// Assumes byte addressing with 32-bit words; bit-per-line blocks span 32 bytes.
package sisc_pkg;
    localparam int ADDR_W = 11;

    // Block selector is addr[10:5] for the low half of the map.
    localparam logic [5:0] BLK_CTRL = 6'd0;
    localparam logic [5:0] BLK_POL  = 6'd2;
    localparam logic [5:0] BLK_TRIG = 6'd3;
    localparam logic [5:0] BLK_DUAL = 6'd4;
    localparam logic [5:0] BLK_MSET = 6'd5;
    localparam logic [5:0] BLK_MCLR = 6'd6;
    localparam logic [5:0] BLK_MASK = 6'd7;
    localparam logic [5:0] BLK_PEND = 6'd8;

    // Word index inside the control block.
    localparam logic [2:0] CTRL_CFG  = 3'd0;
    localparam logic [2:0] CTRL_EDGE = 3'd1;

    typedef struct packed {
        logic       to_pin;
        logic       to_nmi;
        logic [5:0] pin;
    } route_t;
endpackage

// File: rtl/sisc_line.sv
// Conditions one interrupt line into a pending bit.
// Assumes in_i is synchronous to clk and low during reset. Edge state is
// sticky until a software clear; a hardware edge wins over a same-cycle clear.
module sisc_line (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    input  logic pol_i,
    input  logic trig_i,
    input  logic dual_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    output logic pend_o
);
    logic in_q;
    logic edge_q;
    logic rise;
    logic fall;
    logic hit;

    // Detect the configured edge against the previous-cycle input.
    always_comb begin
        rise = in_i & ~in_q;
        fall = ~in_i & in_q;
        if (dual_i) hit = trig_i & (rise | fall);
        else        hit = trig_i & (pol_i ? rise : fall);
    end

    // Keep the previous input and the latched edge state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            in_q   <= in_i;
            edge_q <= hit | sw_set_i | (edge_q & ~sw_clr_i);
        end
    end

    // Select the level view or the latched edge view.
    assign pend_o = trig_i ? edge_q : (pol_i ? in_i : ~in_i);

    assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q && !sw_clr_i) |=> edge_q);
    assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !dual_i && pol_i && in_i && !in_q) |=> edge_q);
    assert_dual_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && dual_i && (in_i != in_q)) |=> edge_q);
    assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_i && !sw_set_i && !trig_i) |=> !edge_q);
endmodule

// File: rtl/sisc_regs.sv
// Register bank: line configuration, mask, routes, edge commands and read mux.
// Assumes NUM_LINES <= 255 so the count fits its 8-bit config field.
module sisc_regs
    import sisc_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    input  logic [NUM_LINES-1:0]        pend_i,
    output logic [NUM_LINES-1:0]        pol_o,
    output logic [NUM_LINES-1:0]        trig_o,
    output logic [NUM_LINES-1:0]        dual_o,
    output logic [NUM_LINES-1:0]        mask_o,
    output logic [NUM_LINES-1:0]        sw_set_o,
    output logic [NUM_LINES-1:0]        sw_clr_o,
    output route_t [NUM_LINES-1:0]      route_o
);
    logic [5:0] blk;
    logic       is_route;
    logic       unused_bits;

    assign blk         = addr[10:5];
    assign is_route    = addr[10];
    assign unused_bits = ^{addr[1:0], wdata[29:8]};

    // Store configuration, mask and route state on bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_o   <= '1;
            trig_o  <= '0;
            dual_o  <= '0;
            mask_o  <= '0;
            route_o <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (!is_route && int'(addr[4:2]) == i / 32) begin
                    case (blk)
                        BLK_POL:  pol_o[i]  <= wdata[i % 32];
                        BLK_TRIG: trig_o[i] <= wdata[i % 32];
                        BLK_DUAL: dual_o[i] <= wdata[i % 32];
                        BLK_MSET: if (wdata[i % 32]) mask_o[i] <= 1'b1;
                        BLK_MCLR: if (wdata[i % 32]) mask_o[i] <= 1'b0;
                        default:  ;
                    endcase
                end
                if (is_route && int'(addr[9:2]) == i)
                    route_o[i] <= '{to_pin: wdata[31], to_nmi: wdata[30], pin: wdata[5:0]};
            end
        end
    end

    // Decode edge-command writes into per-line set and clear pulses.
    always_comb begin
        sw_set_o = '0;
        sw_clr_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (wr_en && !is_route && blk == BLK_CTRL && addr[4:2] == CTRL_EDGE
                && int'(wdata[7:0]) == i) begin
                sw_set_o[i] = wdata[31];
                sw_clr_o[i] = ~wdata[31];
            end
        end
    end

    // Return the addressed word.
    always_comb begin
        rdata = '0;
        if (is_route) begin
            for (int i = 0; i < NUM_LINES; i++)
                if (int'(addr[9:2]) == i)
                    rdata = {route_o[i].to_pin, route_o[i].to_nmi, 24'd0, route_o[i].pin};
        end else if (blk == BLK_CTRL) begin
            if (addr[4:2] == CTRL_CFG) rdata[23:16] = 8'(NUM_LINES);
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (int'(addr[4:2]) == i / 32) begin
                    case (blk)
                        BLK_POL:  rdata[i % 32] = pol_o[i];
                        BLK_TRIG: rdata[i % 32] = trig_o[i];
                        BLK_DUAL: rdata[i % 32] = dual_o[i];
                        BLK_MASK: rdata[i % 32] = mask_o[i];
                        BLK_PEND: rdata[i % 32] = pend_i[i];
                        default:  ;
                    endcase
                end
            end
        end
    end

    assert_mask_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !is_route && (blk == BLK_MSET || blk == BLK_MCLR)) |=> $stable(mask_o));
endmodule

// File: rtl/sisc_route.sv
// Merges active lines onto output pins and the non-maskable output.
// Assumes act_i is already pending-and-unmasked; out-of-range pins are dropped.
module sisc_route
    import sisc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NUM_PINS  = 4
) (
    input  logic [NUM_LINES-1:0]   act_i,
    input  route_t [NUM_LINES-1:0] route_i,
    output logic [NUM_PINS-1:0]    pin_o,
    output logic                   nmi_o
);
    // OR each active line into its selected destinations.
    always_comb begin
        pin_o = '0;
        nmi_o = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (act_i[i]) begin
                if (route_i[i].to_nmi) nmi_o = 1'b1;
                if (route_i[i].to_pin)
                    for (int p = 0; p < NUM_PINS; p++)
                        if (route_i[i].pin == 6'(p)) pin_o[p] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sisc_top.sv
// Shared interrupt source controller top: per-line conditioning, register
// bank and output routing. Assumes irq_in is synchronous to clk.
module sisc_top
    import sisc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int NUM_PINS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic                 nmi_out
);
    logic [NUM_LINES-1:0]   pend;
    logic [NUM_LINES-1:0]   pol;
    logic [NUM_LINES-1:0]   trig;
    logic [NUM_LINES-1:0]   dual;
    logic [NUM_LINES-1:0]   mask;
    logic [NUM_LINES-1:0]   sw_set;
    logic [NUM_LINES-1:0]   sw_clr;
    route_t [NUM_LINES-1:0] route;

    sisc_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pend_i(pend), .pol_o(pol), .trig_o(trig), .dual_o(dual),
        .mask_o(mask), .sw_set_o(sw_set), .sw_clr_o(sw_clr), .route_o(route)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        sisc_line u_line (
            .clk(clk), .rst_n(rst_n), .in_i(irq_in[g]), .pol_i(pol[g]),
            .trig_i(trig[g]), .dual_i(dual[g]), .sw_set_i(sw_set[g]),
            .sw_clr_i(sw_clr[g]), .pend_o(pend[g])
        );
    end

    sisc_route #(.NUM_LINES(NUM_LINES), .NUM_PINS(NUM_PINS)) u_route (
        .act_i(pend & mask), .route_i(route), .pin_o(pin_out), .nmi_o(nmi_out)
    );

    assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (pin_out == '0 && !nmi_out));
endmodule

// File: tb/sisc_top_tb.sv
module sisc_top_tb;
    localparam int NL = 8;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [10:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_out;
    logic          nmi_out;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sisc_top #(.NUM_LINES(NL), .NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .nmi_out(nmi_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(11'h100, d); chk("R1 pending after reset", d, 32'h0);
        rd(11'h0E0, d); chk("R1 mask after reset", d, 32'h0);
        rd(11'h040, d); chk("R1 polarity after reset", d, 32'h0000_00FF);
        chk("R1 outputs after reset", {27'd0, nmi_out, pin_out}, 32'h0);
        rd(11'h000, d); chk("R10 config line count", d, 32'h0008_0000);
    endtask

    task automatic t_level();
        logic [31:0] d;
        step(); irq_in[0] = 1'b1;
        rd(11'h100, d); chk("R2 active-high level set", d, 32'h1);
        step(); irq_in[0] = 1'b0;
        rd(11'h100, d); chk("R2 level not latched", d, 32'h0);
        wr(11'h040, 32'hFD);
        rd(11'h100, d); chk("R2 active-low idle input pending", d, 32'h2);
        step(); irq_in[1] = 1'b1;
        rd(11'h100, d); chk("R2 active-low driven high clears", d, 32'h0);
        step(); irq_in[1] = 1'b0;
        wr(11'h040, 32'hFF);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(11'h060, 32'h04);
        step(); irq_in[2] = 1'b1; step();
        rd(11'h100, d); chk("R3 rising edge latched", d, 32'h4);
        step(); irq_in[2] = 1'b0; step();
        rd(11'h100, d); chk("R5 stays pending after input drops", d, 32'h4);
        wr(11'h004, 32'h0000_0002);
        rd(11'h100, d); chk("R5 software clear", d, 32'h0);
        step(); irq_in[2] = 1'b1; step();
        wr(11'h004, 32'h0000_0002);
        step(); irq_in[2] = 1'b0; step();
        rd(11'h100, d); chk("R3 falling ignored on rising polarity", d, 32'h0);
        wr(11'h040, 32'hFB);
        step(); irq_in[2] = 1'b1; step();
        rd(11'h100, d); chk("R3 rising ignored on falling polarity", d, 32'h0);
        step(); irq_in[2] = 1'b0; step();
        rd(11'h100, d); chk("R3 falling edge latched", d, 32'h4);
        wr(11'h004, 32'h0000_0002);
        wr(11'h040, 32'hFF);
    endtask

    task automatic t_dual();
        logic [31:0] d;
        wr(11'h060, 32'h0C);
        wr(11'h080, 32'h08);
        step(); irq_in[3] = 1'b1; step();
        rd(11'h100, d); chk("R4 dual rising", d, 32'h8);
        wr(11'h004, 32'h0000_0003);
        rd(11'h100, d); chk("R5 dual cleared", d, 32'h0);
        step(); irq_in[3] = 1'b0; step();
        rd(11'h100, d); chk("R4 dual falling", d, 32'h8);
        wr(11'h004, 32'h0000_0003);
    endtask

    task automatic t_swedge();
        logic [31:0] d;
        wr(11'h060, 32'h1C);
        wr(11'h004, 32'h8000_0004);
        rd(11'h100, d); chk("R6 software set", d, 32'h10);
        wr(11'h004, 32'h0000_0004);
        rd(11'h100, d); chk("R5 software clear of injected edge", d, 32'h0);
        wr(11'h004, 32'h8000_0009);
        rd(11'h100, d); chk("R10 out-of-range line ignored", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(11'h0A0, 32'h05);
        rd(11'h0E0, d); chk("R7 set mask", d, 32'h05);
        wr(11'h0A0, 32'h00);
        rd(11'h0E0, d); chk("R7 zero set write no effect", d, 32'h05);
        wr(11'h0C0, 32'h01);
        rd(11'h0E0, d); chk("R7 clear mask", d, 32'h04);
        wr(11'h0C0, 32'h00);
        rd(11'h0E0, d); chk("R7 zero clear write no effect", d, 32'h04);
        wr(11'h0A0, 32'h02);
        rd(11'h0E0, d); chk("R7 set keeps others", d, 32'h06);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(11'h0C0, 32'hFF);
        wr(11'h400, 32'h8000_0002);
        wr(11'h0A0, 32'h01);
        step(); irq_in[0] = 1'b1; #1;
        chk("R8 routed to pin 2", {27'd0, nmi_out, pin_out}, 32'h04);
        wr(11'h0C0, 32'h01); #1;
        chk("R8 masked line silent", {27'd0, nmi_out, pin_out}, 32'h00);
        wr(11'h404, 32'h4000_0000);
        wr(11'h0A0, 32'h02);
        step(); irq_in[1] = 1'b1; #1;
        chk("R9 nmi routing", {27'd0, nmi_out, pin_out}, 32'h10);
        wr(11'h400, 32'h8000_0005);
        wr(11'h0A0, 32'h01); #1;
        chk("R8 out-of-range pin drives nothing", {27'd0, nmi_out, pin_out}, 32'h10);
        wr(11'h408, 32'hFFFF_FFFF);
        rd(11'h408, d); chk("R8 route readback fields", d, 32'hC000_003F);
        step(); irq_in = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_level();
        t_edge();
        t_dual();
        t_swedge();
        t_mask();
        t_route();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule